// File: doc/BRIEF.md
# Queued Interrupt Dispatch Controller

This block sits beside a processor core and turns device interrupt requests into handler entries. A device raises a request by giving its number, 1 to 63. Every valid request goes into an arrival-ordered hardware queue. Whenever dispatch is enabled and the queue is not empty, the block takes the oldest entry and reads that device's handler address from a descriptor table in main memory.

Each descriptor is four words long. The descriptor for device 1 starts at word 0x0004, and the handler address is the third word, so the lookup for device n reads word 4n+2. A zero handler address discards the interrupt and leaves dispatch enabled. A nonzero address is offered to the core, which answers with an acknowledge, pushes its PC and jumps to the handler. From the acknowledge onward dispatch stays suspended. It resumes on the interrupt-return pulse from the core, after the core has popped its PC back.

While dispatch is suspended, requests collect in the queue, which holds up to 64 entries. A request that finds the queue full is lost, and this loss is recorded in a sticky flag.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After reset, `mem_rd_o`, `disp_valid_o`, `busy_o` and `ovf_o` are all 0.
- R2: A request with device number 0 is never queued and never causes a descriptor read.
- R3: The descriptor read for device n pulses `mem_rd_o` for one cycle with `mem_addr_o` = 4*n+2. The handler word is expected on `mem_rdata_i` in the following cycle.
- R4: If the handler word is 0, no dispatch is offered. If another entry is queued, its descriptor read happens two cycles after the previous read.
- R5: If the handler word is nonzero, `disp_valid_o` rises in the cycle after the data cycle. It then stays high with a stable `disp_addr_o` equal to the handler word until the cycle in which `disp_ack_i` is high.
- R6: After the acknowledge, `busy_o` stays 1 and no descriptor read occurs until `irt_i` is pulsed.
- R7: Queued entries are dispatched in arrival order, one for each interrupt return.
- R8: The queue holds 64 entries. A request made while 64 are held is dropped and sets `ovf_o`, and `ovf_o` remains 1 until reset.
- R9: `irt_i` has no effect unless a handler is running, that is, after the acknowledge.
- R10: A request made in the same cycle as a descriptor read starts is accepted, and it is looked up after the entry being read.
- R11: `busy_o` is 1 from the cycle after a descriptor read until dispatch resumes (after a zero handler, or after `irt_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Interrupt request strobe |
| req_dev_i | input | 6 | Requesting device number |
| mem_rd_o | output | 1 | Descriptor read strobe |
| mem_addr_o | output | 16 | Descriptor word address |
| mem_rdata_i | input | 16 | Read data, one cycle after the strobe |
| disp_valid_o | output | 1 | Handler entry offered to the core |
| disp_addr_o | output | 16 | Handler address |
| disp_ack_i | input | 1 | Core accepts the handler entry |
| irt_i | input | 1 | Interrupt return pulse from the core |
| busy_o | output | 1 | Dispatch suspended |
| ovf_o | output | 1 | Sticky queue overflow flag |

## Verification
Two functions can fall in the same cycle: a new request being pushed into the queue, and the head entry leaving the queue because its descriptor read starts. The bench provokes this by holding a second request in the cycle in which the first request's read strobe is visible. It then checks that the second device's read appears exactly two cycles later (R4, R10). The full-queue case is judged by counting descriptor reads for each address after the queue drains: the 64 held entries are all read, and the 65th request is never read.

// File: rtl/idc_pkg.sv
package idc_pkg;
  localparam int unsigned DEV_W  = 6;
  localparam int unsigned ADDR_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_OFFER,
    ST_RUN
  } idc_state_e;
endpackage

// File: rtl/idc_fifo.sv
module idc_fifo #(
  parameter int unsigned W     = 6,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  logic do_push, do_pop;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/idc_admit.sv
module idc_admit #(
  parameter int unsigned DEV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [DEV_W-1:0] req_dev_i,
  input  logic             q_full_i,
  output logic             push_o,
  output logic             ovf_o
);
  logic dev_ok;
  assign dev_ok = (req_dev_i != '0);
  assign push_o = req_valid_i && dev_ok && !q_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               ovf_o <= 1'b0;
    else if (req_valid_i && dev_ok && q_full_i) ovf_o <= 1'b1;
  end
endmodule

// File: rtl/idc_seq.sv
module idc_seq
  import idc_pkg::*;
#(
  parameter int unsigned DESC_BASE   = 4,
  parameter int unsigned DESC_WORDS  = 4,
  parameter int unsigned HANDLER_OFS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              head_valid_i,
  input  logic [DEV_W-1:0]  head_dev_i,
  output logic              pop_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              disp_valid_o,
  output logic [ADDR_W-1:0] disp_addr_o,
  input  logic              disp_ack_i,
  input  logic              irt_i,
  output logic              busy_o
);
  idc_state_e st_q;
  logic [ADDR_W-1:0] hnd_q;
  logic [ADDR_W-1:0] dev_ext;

  assign dev_ext    = ADDR_W'(head_dev_i);
  assign mem_rd_o   = (st_q == ST_IDLE) && head_valid_i;
  assign pop_o      = mem_rd_o;
  assign mem_addr_o = ADDR_W'(DESC_BASE + HANDLER_OFS)
                    + ADDR_W'(DESC_WORDS) * (dev_ext - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      hnd_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (head_valid_i) st_q <= ST_LOOK;
        ST_LOOK: begin
          // zero handler: drop and re-enable at once
          if (mem_rdata_i != '0) begin
            st_q  <= ST_OFFER;
            hnd_q <= mem_rdata_i;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_OFFER: if (disp_ack_i) st_q <= ST_RUN;
        ST_RUN:   if (irt_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign disp_valid_o = (st_q == ST_OFFER);
  assign disp_addr_o  = hnd_q;
  assign busy_o       = (st_q != ST_IDLE);
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import idc_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [DEV_W-1:0]  req_dev_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              disp_valid_o,
  output logic [ADDR_W-1:0] disp_addr_o,
  input  logic              disp_ack_i,
  input  logic              irt_i,
  output logic              busy_o,
  output logic              ovf_o
);
  logic             push, pop, q_empty, q_full;
  logic [DEV_W-1:0] head_dev;
  logic [CW-1:0]    q_cnt;

  idc_admit #(.DEV_W(DEV_W)) u_admit (
    .clk_i, .rst_ni,
    .req_valid_i, .req_dev_i,
    .q_full_i (q_full),
    .push_o   (push),
    .ovf_o
  );

  idc_fifo #(.W(DEV_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (push),
    .din_i   (req_dev_i),
    .pop_i   (pop),
    .dout_o  (head_dev),
    .empty_o (q_empty),
    .full_o  (q_full),
    .cnt_o   (q_cnt)
  );

  idc_seq u_seq (
    .clk_i, .rst_ni,
    .head_valid_i (!q_empty),
    .head_dev_i   (head_dev),
    .pop_o        (pop),
    .mem_rd_o, .mem_addr_o, .mem_rdata_i,
    .disp_valid_o, .disp_addr_o, .disp_ack_i,
    .irt_i, .busy_o
  );
endmodule

// File: rtl/idc_chk.sv
module idc_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_rd_o,
  input logic [15:0]   mem_addr_o,
  input logic          disp_valid_o,
  input logic [15:0]   disp_addr_o,
  input logic          disp_ack_i,
  input logic          busy_o,
  input logic          ovf_o,
  input logic [CW-1:0] q_cnt
);
  // R5
  disp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && !disp_ack_i |=> disp_valid_o && $stable(disp_addr_o));
  // R5
  disp_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> disp_addr_o != 16'h0);
  // R3
  look_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> mem_addr_o[1:0] == 2'b10 && mem_addr_o >= 16'd6 && mem_addr_o <= 16'd254);
  // R4
  look_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o && busy_o);
  // R6
  run_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && disp_ack_i |=> busy_o && !mem_rd_o && !disp_valid_o);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R8
  q_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_cnt <= CW'(DEPTH));
endmodule

bind irq_dispatch_ctrl idc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .mem_rd_o, .mem_addr_o, .disp_valid_o, .disp_addr_o,
  .disp_ack_i, .busy_o, .ovf_o, .q_cnt
);

// File: tb/irq_dispatch_ctrl_bench.sv
module irq_dispatch_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, disp_ack = 1'b0, irt = 1'b0;
  logic [5:0] req_dev = '0;
  logic mem_rd, disp_valid, busy, ovf;
  logic [15:0] mem_addr, disp_addr, rdata;
  logic [15:0] mem [256];
  int lk_cnt [256];
  int tot_rd = 0, n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch_ctrl u_irq_dispatch_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_dev_i(req_dev),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(rdata),
    .disp_valid_o(disp_valid), .disp_addr_o(disp_addr), .disp_ack_i(disp_ack),
    .irt_i(irt), .busy_o(busy), .ovf_o(ovf)
  );

  always_ff @(posedge clk) begin
    if (mem_rd) begin
      rdata <= mem[mem_addr[7:0]];
      lk_cnt[mem_addr[7:0]] <= lk_cnt[mem_addr[7:0]] + 1;
      tot_rd <= tot_rd + 1;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d exp<100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [5:0] dev);
    req_valid = 1'b1; req_dev = dev;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_irt();
    irt = 1'b1; @(negedge clk); irt = 1'b0;
  endtask

  task automatic serve(input logic [15:0] exp, input string req);
    int k;
    k = 0;
    while (!disp_valid && k < 20) begin @(negedge clk); k++; end
    chk(disp_valid && disp_addr == exp, req, disp_addr, exp);
    disp_ack = 1'b1; @(negedge clk); disp_ack = 1'b0;
    chk(busy && !disp_valid, "R6", {busy, disp_valid}, 2'b10);
  endtask

  task automatic t_reset();
    chk(!mem_rd && !disp_valid && !busy && !ovf, "R1", {mem_rd, disp_valid, busy, ovf}, 0);
    rst_n = 1'b1; tick(2);
    chk(!mem_rd && !disp_valid && !busy && !ovf, "R1", {mem_rd, disp_valid, busy, ovf}, 0);
  endtask

  task automatic t_dev0();
    send(6'd0); tick(3);
    chk(tot_rd == 0 && !busy, "R2", tot_rd, 0);
  endtask

  task automatic t_lookup();
    send(6'd5);
    chk(mem_rd && mem_addr == 16'h0016, "R3", mem_addr, 16'h0016);
    tick(1);
    chk(!mem_rd && busy, "R11", {mem_rd, busy}, 2'b01);
    tick(1);
    chk(disp_valid && disp_addr == 16'h1234, "R5", disp_addr, 16'h1234);
    tick(3);
    chk(disp_valid && disp_addr == 16'h1234, "R5", disp_addr, 16'h1234);
    serve(16'h1234, "R5");
    send(6'd7); tick(4);
    chk(lk_cnt[30] == 0 && busy, "R6", lk_cnt[30], 0);
    pulse_irt();
    serve(16'h2000, "R6");
    chk(lk_cnt[30] == 1, "R3", lk_cnt[30], 1);
    pulse_irt(); tick(1);
    chk(!busy, "R11", busy, 0);
  endtask

  task automatic t_zero_handler();
    req_valid = 1'b1; req_dev = 6'd9;
    @(negedge clk);
    chk(mem_rd && mem_addr == 16'h0026, "R3", mem_addr, 16'h0026);
    req_dev = 6'd10; // R10: pushed while head leaves
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_rd && busy, "R11", {mem_rd, busy}, 2'b01);
    @(negedge clk);
    chk(mem_rd && mem_addr == 16'h002a && !disp_valid, "R4", mem_addr, 16'h002a);
    serve(16'h3000, "R10");
    pulse_irt();
  endtask

  task automatic t_order();
    send(6'd5); serve(16'h1234, "R7");
    send(6'd3); send(6'd4); send(6'd6);
    pulse_irt(); serve(16'h0300, "R7");
    pulse_irt(); serve(16'h0400, "R7");
    pulse_irt(); serve(16'h0600, "R7");
    pulse_irt(); tick(3);
    chk(!busy, "R7", busy, 0);
  endtask

  task automatic t_irt_ignored();
    pulse_irt(); tick(2);
    chk(!busy && !disp_valid, "R9", {busy, disp_valid}, 0);
    send(6'd5); tick(2);
    chk(disp_valid, "R9", disp_valid, 1);
    pulse_irt();
    chk(disp_valid && disp_addr == 16'h1234, "R9", disp_addr, 16'h1234);
    serve(16'h1234, "R9");
    pulse_irt();
  endtask

  task automatic t_overflow();
    send(6'd5); serve(16'h1234, "R8");
    for (int i = 0; i < 64; i++) send(6'd11);
    chk(!ovf, "R8", ovf, 0);
    send(6'd12);
    chk(ovf, "R8", ovf, 1);
    pulse_irt(); tick(200);
    chk(lk_cnt[46] == 64, "R8", lk_cnt[46], 64);
    chk(lk_cnt[50] == 0, "R8", lk_cnt[50], 0);
    chk(ovf && !busy, "R8", {ovf, busy}, 2'b10);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; lk_cnt[i] = 0; end
    mem[22] = 16'h1234; mem[30] = 16'h2000; mem[38] = 16'h0; mem[42] = 16'h3000;
    mem[14] = 16'h0300; mem[18] = 16'h0400; mem[26] = 16'h0600;
    mem[46] = 16'h0;    mem[50] = 16'h5000;
    tick(2);
    t_reset();
    t_dev0();
    t_lookup();
    t_zero_handler();
    t_order();
    t_irt_ignored();
    t_overflow();
    finish_run();
  end
endmodule